// File: doc/BRIEF.md
# Miss Status Holding Register File

This block keeps track of cache line misses that are still outstanding in a non-blocking data cache placed in front of an in-order pipeline. Each entry covers one whole memory line. An entry holds the line address and, for each word of that line, the destination register that is waiting for that word, if there is one. A load that misses claims an entry, or joins the entry already open for its line. Its destination register is then marked empty and the load leaves the pipeline at once.

Memory fills come back one word per cycle. Each fill word is tagged with its line address and word index. When a waiting register exists for that word, the block presents a register write in the same cycle, and the register's empty mark clears on the next clock edge. The word flagged as last releases the entry on that same edge. Decode logic asks the block whether a source register is still empty and stalls while it is.

Top module: `mshr_file`

## Requirements
- R1: After reset no entry is open and no register is marked empty. With free entries and no pending destination, `miss_ready_o` is 1, `wb_valid_o` is 0 and `query_empty_o` is 0 for every register.
- R2: A miss that is accepted (`miss_valid_i` and `miss_ready_o` both 1) to a line with no open entry opens the lowest-numbered free entry. From the next cycle on, its destination register reads as empty.
- R3: A miss to a line that already has an open entry joins that entry and uses no new one. Every register recorded in the entry is written when its word index arrives in a fill.
- R4: While all 4 entries are open, a miss to a line that has no entry sees `miss_ready_o` 0. A miss that joins an open entry is still accepted.
- R5: A miss to a word whose slot in the matching entry already holds a register sees `miss_ready_o` 0, and its register is not marked empty.
- R6: A miss whose destination register is already marked empty sees `miss_ready_o` 0.
- R7: A fill word (`fill_word_i` selects the word within the line) for which a register is waiting raises `wb_valid_o` in the same cycle, with that register on `wb_rd_o` and `fill_data_i` on `wb_data_o`. The register reads as not empty from the next cycle on.
- R8: A fill word with no waiting register leaves `wb_valid_o` at 0.
- R9: A fill word with `fill_last_i` 1 frees its entry on that clock edge, so a new line can be allocated in the very next cycle.
- R10: A miss to a line whose fill has started, or whose fill word arrives in the same cycle, sees `miss_ready_o` 0.
- R11: A fill whose line matches no open entry is ignored. No write-back happens and no open entry changes.
- R12: `query_empty_o` shows the empty mark of the register selected by `query_rd_i`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| miss_valid_i | input | 1 | Load miss request present |
| miss_ready_o | output | 1 | Miss request can be taken this cycle |
| miss_line_i | input | LINE_AW | Line address of the miss |
| miss_word_i | input | log2(WORDS) | Word index within the line |
| miss_rd_i | input | REG_W | Destination register of the load |
| fill_valid_i | input | 1 | Fill word present |
| fill_line_i | input | LINE_AW | Line address of the fill word |
| fill_word_i | input | log2(WORDS) | Word index of the fill word |
| fill_data_i | input | DATA_W | Fill data |
| fill_last_i | input | 1 | Final word of the line's fill |
| wb_valid_o | output | 1 | Register write-back this cycle |
| wb_rd_o | output | REG_W | Register being written |
| wb_data_o | output | DATA_W | Data being written |
| query_rd_i | input | REG_W | Register asked about by decode |
| query_empty_o | output | 1 | Queried register is still waiting |

## Verification
Misses are sent to distinct lines until the table is full, and to an open line at a different word. The first case shows that allocation is separate from merging, and the second shows that merging still works while the table is full. A repeated word and a destination that is already pending are tried to show that each stall cause is caught on its own. Fills arrive with and without a waiting register, with the last flag on the first and on a later word, and in the same cycle as a miss to the same line. A fill to an unknown line is also tried. These show that write-back, entry release and the fill-in-progress stall are correct and separate from one another.

// File: rtl/mshr_pkg.sv
`timescale 1ns/1ps
package mshr_pkg;
  localparam int unsigned MSHR_ENTRIES = 4;
  localparam int unsigned MSHR_WORDS   = 4;
  localparam int unsigned MSHR_LINE_AW = 26;
  localparam int unsigned MSHR_REG_W   = 5;
  localparam int unsigned MSHR_DATA_W  = 32;
endpackage

// File: rtl/mshr_entry.sv
`timescale 1ns/1ps
module mshr_entry #(
  parameter int unsigned LINE_AW = mshr_pkg::MSHR_LINE_AW,
  parameter int unsigned WORDS   = mshr_pkg::MSHR_WORDS,
  parameter int unsigned REG_W   = mshr_pkg::MSHR_REG_W,
  localparam int unsigned WORD_W = $clog2(WORDS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               alloc_i,
  input  logic               merge_i,
  input  logic [LINE_AW-1:0] req_line_i,
  input  logic [WORD_W-1:0]  req_word_i,
  input  logic [REG_W-1:0]   req_rd_i,
  input  logic               fill_valid_i,
  input  logic [LINE_AW-1:0] fill_line_i,
  input  logic [WORD_W-1:0]  fill_word_i,
  input  logic               fill_last_i,
  output logic               valid_o,
  output logic               req_match_o,
  output logic               slot_busy_o,
  output logic               filling_o,
  output logic               fill_hit_o,
  output logic               wb_valid_o,
  output logic [REG_W-1:0]   wb_rd_o
);
  logic                        valid_q, filling_q;
  logic [LINE_AW-1:0]          line_q;
  logic [WORDS-1:0]            wait_v_q;
  logic [WORDS-1:0][REG_W-1:0] wait_rd_q;

  assign valid_o     = valid_q;
  assign filling_o   = filling_q;
  assign req_match_o = valid_q && (line_q == req_line_i);
  assign slot_busy_o = wait_v_q[req_word_i];
  assign fill_hit_o  = fill_valid_i && valid_q && (line_q == fill_line_i);
  assign wb_valid_o  = fill_hit_o && wait_v_q[fill_word_i];
  assign wb_rd_o     = wait_rd_q[fill_word_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      filling_q <= 1'b0;
      line_q    <= '0;
      wait_v_q  <= '0;
      wait_rd_q <= '0;
    end else begin
      if (alloc_i) begin
        valid_q                <= 1'b1;
        filling_q              <= 1'b0;
        line_q                 <= req_line_i;
        wait_v_q               <= {{(WORDS-1){1'b0}}, 1'b1} << req_word_i;
        wait_rd_q[req_word_i]  <= req_rd_i;
      end else if (merge_i) begin
        wait_v_q[req_word_i]   <= 1'b1;
        wait_rd_q[req_word_i]  <= req_rd_i;
      end
      if (fill_hit_o) begin
        wait_v_q[fill_word_i] <= 1'b0;
        filling_q             <= !fill_last_i;
        if (fill_last_i) begin
          valid_q  <= 1'b0;
          wait_v_q <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/mshr_pick.sv
`timescale 1ns/1ps
module mshr_pick #(
  parameter int unsigned N = mshr_pkg::MSHR_ENTRIES
) (
  input  logic [N-1:0] free_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);
  // lowest free index wins
  always_comb begin
    grant_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        grant_o    = '0;
        grant_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |free_i;
endmodule

// File: rtl/mshr_scoreboard.sv
`timescale 1ns/1ps
module mshr_scoreboard #(
  parameter int unsigned REG_W = mshr_pkg::MSHR_REG_W,
  localparam int unsigned N_REGS = 1 << REG_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic [REG_W-1:0]  set_rd_i,
  input  logic              clr_i,
  input  logic [REG_W-1:0]  clr_rd_i,
  input  logic [REG_W-1:0]  qa_rd_i,
  output logic              qa_empty_o,
  input  logic [REG_W-1:0]  qb_rd_i,
  output logic              qb_empty_o,
  output logic [N_REGS-1:0] empty_o
);
  logic [N_REGS-1:0] empty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      empty_q <= '0;
    end else begin
      if (clr_i) empty_q[clr_rd_i] <= 1'b0;
      if (set_i) empty_q[set_rd_i] <= 1'b1;
    end
  end

  assign qa_empty_o = empty_q[qa_rd_i];
  assign qb_empty_o = empty_q[qb_rd_i];
  assign empty_o    = empty_q;
endmodule

// File: rtl/mshr_file.sv
`timescale 1ns/1ps
module mshr_file #(
  parameter int unsigned N_ENT   = mshr_pkg::MSHR_ENTRIES,
  parameter int unsigned WORDS   = mshr_pkg::MSHR_WORDS,
  parameter int unsigned LINE_AW = mshr_pkg::MSHR_LINE_AW,
  parameter int unsigned REG_W   = mshr_pkg::MSHR_REG_W,
  parameter int unsigned DATA_W  = mshr_pkg::MSHR_DATA_W,
  localparam int unsigned WORD_W = $clog2(WORDS),
  localparam int unsigned N_REGS = 1 << REG_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               miss_valid_i,
  output logic               miss_ready_o,
  input  logic [LINE_AW-1:0] miss_line_i,
  input  logic [WORD_W-1:0]  miss_word_i,
  input  logic [REG_W-1:0]   miss_rd_i,
  input  logic               fill_valid_i,
  input  logic [LINE_AW-1:0] fill_line_i,
  input  logic [WORD_W-1:0]  fill_word_i,
  input  logic [DATA_W-1:0]  fill_data_i,
  input  logic               fill_last_i,
  output logic               wb_valid_o,
  output logic [REG_W-1:0]   wb_rd_o,
  output logic [DATA_W-1:0]  wb_data_o,
  input  logic [REG_W-1:0]   query_rd_i,
  output logic               query_empty_o
);
  logic [N_ENT-1:0] valid, match, busy, filling, fill_hit, ent_wb, grant, alloc, merge;
  logic [N_ENT-1:0][REG_W-1:0] ent_rd;
  logic             any_free, any_match, sel_busy, sel_filling, sel_fill_hit;
  logic             rd_pending, accept;
  logic [N_REGS-1:0] empty_vec;

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    mshr_entry #(.LINE_AW(LINE_AW), .WORDS(WORDS), .REG_W(REG_W)) u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .alloc_i     (alloc[g]),
      .merge_i     (merge[g]),
      .req_line_i  (miss_line_i),
      .req_word_i  (miss_word_i),
      .req_rd_i    (miss_rd_i),
      .fill_valid_i(fill_valid_i),
      .fill_line_i (fill_line_i),
      .fill_word_i (fill_word_i),
      .fill_last_i (fill_last_i),
      .valid_o     (valid[g]),
      .req_match_o (match[g]),
      .slot_busy_o (busy[g]),
      .filling_o   (filling[g]),
      .fill_hit_o  (fill_hit[g]),
      .wb_valid_o  (ent_wb[g]),
      .wb_rd_o     (ent_rd[g])
    );
  end

  mshr_pick #(.N(N_ENT)) u_pick (
    .free_i (~valid),
    .grant_o(grant),
    .any_o  (any_free)
  );

  always_comb begin
    sel_busy     = 1'b0;
    sel_filling  = 1'b0;
    sel_fill_hit = 1'b0;
    wb_rd_o      = '0;
    for (int i = 0; i < N_ENT; i++) begin
      sel_busy     |= match[i] & busy[i];
      sel_filling  |= match[i] & filling[i];
      sel_fill_hit |= match[i] & fill_hit[i];
      wb_rd_o      |= ent_wb[i] ? ent_rd[i] : '0;
    end
  end

  assign any_match    = |match;
  assign miss_ready_o = !rd_pending &&
                        (any_match ? !(sel_busy || sel_filling || sel_fill_hit) : any_free);
  assign accept       = miss_valid_i && miss_ready_o;
  assign alloc        = (accept && !any_match) ? grant : '0;
  assign merge        = (accept &&  any_match) ? match : '0;

  assign wb_valid_o = |ent_wb;
  assign wb_data_o  = fill_data_i;

  mshr_scoreboard #(.REG_W(REG_W)) u_sb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (accept),
    .set_rd_i  (miss_rd_i),
    .clr_i     (wb_valid_o),
    .clr_rd_i  (wb_rd_o),
    .qa_rd_i   (query_rd_i),
    .qa_empty_o(query_empty_o),
    .qb_rd_i   (miss_rd_i),
    .qb_empty_o(rd_pending),
    .empty_o   (empty_vec)
  );
endmodule

// File: rtl/mshr_file_chk.sv
`timescale 1ns/1ps
module mshr_file_chk #(
  parameter int unsigned N_ENT  = 4,
  parameter int unsigned REG_W  = 5,
  parameter int unsigned N_REGS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              miss_valid_i,
  input logic              miss_ready_o,
  input logic [REG_W-1:0]  miss_rd_i,
  input logic              fill_valid_i,
  input logic              wb_valid_o,
  input logic [REG_W-1:0]  wb_rd_o,
  input logic [N_ENT-1:0]  match_i,
  input logic [N_ENT-1:0]  valid_i,
  input logic [N_REGS-1:0] empty_i
);
  assert_accept_marks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_ready_o) |=> empty_i[$past(miss_rd_i)]);

  assert_open_only_on_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(miss_valid_i && miss_ready_o) |=> ($countones(valid_i) <= $past($countones(valid_i))));

  assert_one_entry_per_line_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));

  assert_pending_rd_stalls_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i[miss_rd_i] |-> !miss_ready_o);

  assert_wb_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |=> !empty_i[$past(wb_rd_o)]);

  assert_wb_needs_fill_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> fill_valid_i);
endmodule

bind mshr_file mshr_file_chk #(.N_ENT(N_ENT), .REG_W(REG_W), .N_REGS(N_REGS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .miss_valid_i(miss_valid_i),
  .miss_ready_o(miss_ready_o),
  .miss_rd_i   (miss_rd_i),
  .fill_valid_i(fill_valid_i),
  .wb_valid_o  (wb_valid_o),
  .wb_rd_o     (wb_rd_o),
  .match_i     (match),
  .valid_i     (valid),
  .empty_i     (empty_vec)
);

// File: tb/mshr_file_bench.sv
`timescale 1ns/1ps
module mshr_file_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [25:0] miss_line = '0;
  logic [1:0]  miss_word = '0;
  logic [4:0]  miss_rd = '0;
  logic        fill_valid = 1'b0;
  logic [25:0] fill_line = '0;
  logic [1:0]  fill_word = '0;
  logic [31:0] fill_data = '0;
  logic        fill_last = 1'b0;
  logic        wb_valid;
  logic [4:0]  wb_rd;
  logic [31:0] wb_data;
  logic [4:0]  query_rd = '0;
  logic        query_empty;

  int checks = 0;
  int fails  = 0;
  logic       o_ready, o_wb;
  logic [4:0] o_rd;
  logic [31:0] o_data;

  always #2.5 clk = ~clk;

  mshr_file u_mshr_file (
    .clk_i(clk), .rst_ni(rst_n),
    .miss_valid_i(miss_valid), .miss_ready_o(miss_ready),
    .miss_line_i(miss_line), .miss_word_i(miss_word), .miss_rd_i(miss_rd),
    .fill_valid_i(fill_valid), .fill_line_i(fill_line), .fill_word_i(fill_word),
    .fill_data_i(fill_data), .fill_last_i(fill_last),
    .wb_valid_o(wb_valid), .wb_rd_o(wb_rd), .wb_data_o(wb_data),
    .query_rd_i(query_rd), .query_empty_o(query_empty)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle of stimulus; combinational outputs captured before the edge
  task automatic step(input bit mv, input logic [25:0] ml, input logic [1:0] mw, input logic [4:0] mr,
                      input bit fv, input logic [25:0] fl, input logic [1:0] fw, input logic [31:0] fd,
                      input bit flast);
    @(negedge clk);
    miss_valid = mv; miss_line = ml; miss_word = mw; miss_rd = mr;
    fill_valid = fv; fill_line = fl; fill_word = fw; fill_data = fd; fill_last = flast;
    #1;
    o_ready = miss_ready; o_wb = wb_valid; o_rd = wb_rd; o_data = wb_data;
    @(posedge clk); #0.5;
    miss_valid = 1'b0; fill_valid = 1'b0; fill_last = 1'b0;
  endtask

  task automatic miss(input logic [25:0] l, input logic [1:0] w, input logic [4:0] r,
                      input bit exp_ready, input string req);
    step(1'b1, l, w, r, 1'b0, '0, '0, '0, 1'b0);
    chk(o_ready == exp_ready, req, "miss_ready", int'(o_ready), int'(exp_ready));
  endtask

  task automatic fill(input logic [25:0] l, input logic [1:0] w, input logic [31:0] d, input bit last,
                      input bit exp_wb, input logic [4:0] exp_rd, input string req);
    step(1'b0, '0, '0, '0, 1'b1, l, w, d, last);
    chk(o_wb == exp_wb, req, "wb_valid", int'(o_wb), int'(exp_wb));
    if (exp_wb) begin
      chk(o_rd == exp_rd, req, "wb_rd", int'(o_rd), int'(exp_rd));
      chk(o_data == d, req, "wb_data", int'(o_data), int'(d));
    end
  endtask

  task automatic query(input logic [4:0] r, input bit exp, input string req);
    @(negedge clk);
    query_rd = r;
    #1;
    chk(query_empty == exp, req, "query_empty", int'(query_empty), int'(exp));
  endtask

  task automatic t_reset;
    int bad = 0;
    for (int r = 0; r < 32; r++) begin
      @(negedge clk); query_rd = 5'(r); #1;
      if (query_empty) bad++;
    end
    chk(bad == 0, "R1", "registers empty after reset", bad, 0);
    @(negedge clk); miss_rd = 5'd5; #1;
    chk(miss_ready == 1'b1, "R1", "miss_ready idle", int'(miss_ready), 1);
    chk(wb_valid == 1'b0, "R1", "wb_valid idle", int'(wb_valid), 0);
  endtask

  task automatic t_alloc_merge;
    miss(26'h100, 2'd1, 5'd3, 1'b1, "R2");
    query(5'd3, 1'b1, "R12");
    query(5'd4, 1'b0, "R12");
    miss(26'h100, 2'd2, 5'd4, 1'b1, "R3");
    query(5'd4, 1'b1, "R2");
    fill(26'h100, 2'd0, 32'hA0, 1'b0, 1'b0, '0, "R8");
    fill(26'h100, 2'd1, 32'hA1, 1'b0, 1'b1, 5'd3, "R7");
    fill(26'h100, 2'd2, 32'hA2, 1'b0, 1'b1, 5'd4, "R3");
    fill(26'h100, 2'd3, 32'hA3, 1'b1, 1'b0, '0, "R8");
    query(5'd3, 1'b0, "R7");
    query(5'd4, 1'b0, "R7");
  endtask

  task automatic t_full;
    miss(26'h200, 2'd0, 5'd1, 1'b1, "R2");
    miss(26'h300, 2'd0, 5'd2, 1'b1, "R2");
    miss(26'h400, 2'd0, 5'd5, 1'b1, "R2");
    miss(26'h500, 2'd0, 5'd6, 1'b1, "R2");
    miss(26'h600, 2'd0, 5'd7, 1'b0, "R4");
    query(5'd7, 1'b0, "R4");
    miss(26'h300, 2'd3, 5'd8, 1'b1, "R4");
    fill(26'h200, 2'd0, 32'hB0, 1'b0, 1'b1, 5'd1, "R7");
    fill(26'h200, 2'd1, 32'hB1, 1'b0, 1'b0, '0, "R8");
    fill(26'h200, 2'd3, 32'hB3, 1'b1, 1'b0, '0, "R9");
    miss(26'h600, 2'd0, 5'd7, 1'b1, "R9");
    fill(26'h300, 2'd0, 32'hC0, 1'b0, 1'b1, 5'd2, "R7");
    fill(26'h300, 2'd3, 32'hC3, 1'b1, 1'b1, 5'd8, "R3");
    fill(26'h400, 2'd0, 32'hD0, 1'b1, 1'b1, 5'd5, "R9");
    fill(26'h500, 2'd0, 32'hE0, 1'b1, 1'b1, 5'd6, "R9");
    fill(26'h600, 2'd0, 32'hF0, 1'b1, 1'b1, 5'd7, "R9");
  endtask

  task automatic t_conflicts;
    miss(26'h700, 2'd2, 5'd9, 1'b1, "R2");
    miss(26'h700, 2'd2, 5'd10, 1'b0, "R5");
    query(5'd10, 1'b0, "R5");
    miss(26'h800, 2'd0, 5'd9, 1'b0, "R6");
    fill(26'h700, 2'd2, 32'h77, 1'b1, 1'b1, 5'd9, "R7");
    miss(26'h800, 2'd0, 5'd9, 1'b1, "R6");
    fill(26'h800, 2'd0, 32'h88, 1'b1, 1'b1, 5'd9, "R7");
  endtask

  task automatic t_filling;
    miss(26'h900, 2'd0, 5'd11, 1'b1, "R2");
    fill(26'h900, 2'd0, 32'h90, 1'b0, 1'b1, 5'd11, "R7");
    miss(26'h900, 2'd1, 5'd12, 1'b0, "R10");
    fill(26'h900, 2'd3, 32'h93, 1'b1, 1'b0, '0, "R10");
    miss(26'hA00, 2'd0, 5'd13, 1'b1, "R2");
    step(1'b1, 26'hA00, 2'd3, 5'd14, 1'b1, 26'hA00, 2'd0, 32'hAA, 1'b0);
    chk(o_ready == 1'b0, "R10", "miss_ready same-cycle fill", int'(o_ready), 0);
    chk(o_wb == 1'b1 && o_rd == 5'd13, "R10", "wb_rd same-cycle fill", int'(o_rd), 13);
    fill(26'hA00, 2'd3, 32'hA3, 1'b1, 1'b0, '0, "R10");
    query(5'd14, 1'b0, "R10");
  endtask

  task automatic t_unknown_fill;
    miss(26'hB00, 2'd1, 5'd15, 1'b1, "R2");
    fill(26'hC00, 2'd1, 32'hCC, 1'b1, 1'b0, '0, "R11");
    query(5'd15, 1'b1, "R11");
    fill(26'hB00, 2'd1, 32'hBB, 1'b1, 1'b1, 5'd15, "R11");
    query(5'd15, 1'b0, "R12");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset;
    t_alloc_merge;
    t_full;
    t_conflicts;
    t_filling;
    t_unknown_fill;
    repeat (2) @(posedge clk);
    summary;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary;
  end
endmodule